// File: doc/BRIEF.md
# Sensor Interrupt Status Aggregator

This block merges eight interrupt sources from the processing functions of a motion sensor into one read-only status byte and one interrupt request line. Each source presents a level. The level is masked by its own enable. A rising edge of the masked level latches a sticky status bit. The host never clears a bit by reading the summary byte. Each bit clears only when the host reads the detail register of its own source. The host then sees which source fired, reads that source's details, and the matching summary bit drops as a side effect of that read.

The host side is a single read strobe with an address. The block watches that strobe and does not return data. The data-ready source needs two reads to clear: first the data status register, then any of the three axis output registers. The FIFO source is formed inside the block from an overflow flag and from a comparison of the sample count against the watermark.

Top module: `sns_irq_agg`

## Requirements
- R1: The status byte holds the sources at fixed positions: bit 7 auto-sleep/wake, bit 6 FIFO, bit 5 transient, bit 4 orientation change, bit 3 pulse, bit 2 freefall/motion 1, bit 1 freefall/motion 2, bit 0 data ready.
- R2: A status bit becomes 1 in the cycle after the clock edge that first samples its masked level high following a low sample. A level that stays high does not set the bit again after the bit is cleared.
- R3: With its enable bit low (irq_en[n] for status bit n), a source never sets its bit. Raising the enable while the source level is high counts as a rising edge and sets the bit.
- R4: The FIFO level is high when fifo_ovf is 1, or when fifo_count equals fifo_wmark.
- R5: A read strobe at the source's own address clears the bit one cycle later: FIFO 0x21, transient 0x22, orientation 0x23, pulse 0x24, motion 1 0x25, motion 2 0x26. Reads of any other address leave the bit unchanged.
- R6: A read at the mode address 0x20 clears the auto-sleep/wake bit.
- R7: The data-ready level is the OR of drdy_new and drdy_ovr. Its bit clears only when a read of 0x27 made while the bit is set is later followed by a read of 0x28, 0x29 or 0x2A. An axis read with no status read before it has no effect, and a new data-ready edge cancels an earlier status read.
- R8: When a rising edge and a clearing read reach the same bit in the same cycle, the bit stays 1.
- R9: irq is 1 exactly when at least one status bit is 1, and it stays high until every set bit has been cleared.
- R10: During reset and in the first cycle after reset, every status bit is 0. A source level that is already high when reset ends does not set its bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_wake | input | 1 | Auto-sleep/wake event level |
| fifo_ovf | input | 1 | FIFO overflow flag |
| fifo_count | input | 6 | FIFO sample count |
| fifo_wmark | input | 6 | FIFO watermark setting |
| evt_trans | input | 1 | Transient event level |
| evt_orient | input | 1 | Orientation change level |
| evt_pulse | input | 1 | Pulse event level |
| evt_mot1 | input | 1 | Freefall/motion 1 event level |
| evt_mot2 | input | 1 | Freefall/motion 2 event level |
| drdy_new | input | 1 | New XYZ sample available |
| drdy_ovr | input | 1 | XYZ sample overrun |
| irq_en | input | 8 | Per-bit interrupt enables, same layout as the status byte |
| rd_stb | input | 1 | Host register read strobe, one cycle per read |
| rd_addr | input | 8 | Address of the register being read |
| status | output | 8 | Sticky interrupt status byte |
| irq | output | 1 | Combined interrupt request |

## Verification
Each status bit is a single sticky register with one edge register in front of it. A wrong internal state therefore shows at the status byte and at irq one cycle after the clock edge that caused it. A missed edge appears as a bit that stays 0. A stale edge register or a stuck bit appears as a bit that stays 1 through a correct clearing read. The cycle-by-cycle scoreboard catches these in the cycle they occur. The two-step data-ready clear keeps a hidden armed flag. An error in that flag shows only when an axis read clears the bit, or fails to clear it, so the bench runs the axis read both before and after a status read, and again after a new edge has arrived.

// File: rtl/sia_pkg.sv
package sia_pkg;
  localparam int NSRC   = 8;
  localparam int ADDR_W = 8;
  localparam int CNT_W  = 6;

  // Bit positions in the status byte; the host decodes these.
  localparam int B_WAKE   = 7;
  localparam int B_FIFO   = 6;
  localparam int B_TRANS  = 5;
  localparam int B_ORIENT = 4;
  localparam int B_PULSE  = 3;
  localparam int B_MOT1   = 2;
  localparam int B_MOT2   = 1;
  localparam int B_DRDY   = 0;
endpackage

// File: rtl/sia_event_gate.sv
module sia_event_gate
  import sia_pkg::*;
#(
  parameter int CW = CNT_W
) (
  input  logic            evt_wake,
  input  logic            fifo_ovf,
  input  logic [CW-1:0]   fifo_count,
  input  logic [CW-1:0]   fifo_wmark,
  input  logic            evt_trans,
  input  logic            evt_orient,
  input  logic            evt_pulse,
  input  logic            evt_mot1,
  input  logic            evt_mot2,
  input  logic            drdy_new,
  input  logic            drdy_ovr,
  input  logic [NSRC-1:0] irq_en,
  output logic [NSRC-1:0] level
);
  logic [NSRC-1:0] raw;

  always_comb begin
    raw           = '0;
    raw[B_WAKE]   = evt_wake;
    raw[B_FIFO]   = fifo_ovf | (fifo_count == fifo_wmark);
    raw[B_TRANS]  = evt_trans;
    raw[B_ORIENT] = evt_orient;
    raw[B_PULSE]  = evt_pulse;
    raw[B_MOT1]   = evt_mot1;
    raw[B_MOT2]   = evt_mot2;
    raw[B_DRDY]   = drdy_new | drdy_ovr;
    level         = raw & irq_en;
  end
endmodule

// File: rtl/sia_status_bit.sv
module sia_status_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic primed,
  input  logic level,
  input  logic clr,
  output logic rise,
  output logic bit_q
);
  logic prev_q, prev_d;
  logic bit_d;

  always_comb begin
    rise   = primed & level & ~prev_q;
    prev_d = level;
    // A new edge wins over a clearing read in the same cycle.
    bit_d  = rise | (bit_q & ~clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      bit_q  <= 1'b0;
    end else begin
      prev_q <= prev_d;
      bit_q  <= bit_d;
    end
  end

  // R2 and R8: an edge always leaves the bit set, even under a clear.
  assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> bit_q);
  assert_set_only_by_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bit_q) |-> $past(rise));
  assert_drop_only_by_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bit_q) |-> $past(clr));
  assert_read_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !rise) |=> !bit_q);
endmodule

// File: rtl/sia_clear_decode.sv
module sia_clear_decode
  import sia_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter logic [AW-1:0] A_MODE   = 'h20,
  parameter logic [AW-1:0] A_FIFO   = 'h21,
  parameter logic [AW-1:0] A_TRANS  = 'h22,
  parameter logic [AW-1:0] A_ORIENT = 'h23,
  parameter logic [AW-1:0] A_PULSE  = 'h24,
  parameter logic [AW-1:0] A_MOT1   = 'h25,
  parameter logic [AW-1:0] A_MOT2   = 'h26,
  parameter logic [AW-1:0] A_DSTAT  = 'h27,
  parameter logic [AW-1:0] A_XDAT   = 'h28,
  parameter logic [AW-1:0] A_YDAT   = 'h29,
  parameter logic [AW-1:0] A_ZDAT   = 'h2A
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rd_stb,
  input  logic [AW-1:0]   rd_addr,
  input  logic            drdy_rise,
  input  logic            drdy_bit,
  output logic [NSRC-1:0] clr
);
  logic armed_q, armed_d;
  logic data_rd;

  always_comb begin
    data_rd = rd_stb & ((rd_addr == A_XDAT) | (rd_addr == A_YDAT) |
                        (rd_addr == A_ZDAT));
    clr           = '0;
    clr[B_WAKE]   = rd_stb & (rd_addr == A_MODE);
    clr[B_FIFO]   = rd_stb & (rd_addr == A_FIFO);
    clr[B_TRANS]  = rd_stb & (rd_addr == A_TRANS);
    clr[B_ORIENT] = rd_stb & (rd_addr == A_ORIENT);
    clr[B_PULSE]  = rd_stb & (rd_addr == A_PULSE);
    clr[B_MOT1]   = rd_stb & (rd_addr == A_MOT1);
    clr[B_MOT2]   = rd_stb & (rd_addr == A_MOT2);
    clr[B_DRDY]   = armed_q & data_rd;

    armed_d = armed_q;
    if (drdy_rise)
      armed_d = 1'b0;
    else if (clr[B_DRDY])
      armed_d = 1'b0;
    else if (rd_stb && (rd_addr == A_DSTAT) && drdy_bit)
      armed_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= armed_d;
  end

  // R7: the first step of the data-ready clear exists only while the bit is set.
  assert_arm_needs_bit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q |-> drdy_bit);
endmodule

// File: rtl/sns_irq_agg.sv
module sns_irq_agg
  import sia_pkg::*;
#(
  parameter int CW = CNT_W,
  parameter int AW = ADDR_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            evt_wake,
  input  logic            fifo_ovf,
  input  logic [CW-1:0]   fifo_count,
  input  logic [CW-1:0]   fifo_wmark,
  input  logic            evt_trans,
  input  logic            evt_orient,
  input  logic            evt_pulse,
  input  logic            evt_mot1,
  input  logic            evt_mot2,
  input  logic            drdy_new,
  input  logic            drdy_ovr,
  input  logic [NSRC-1:0] irq_en,
  input  logic            rd_stb,
  input  logic [AW-1:0]   rd_addr,
  output logic [NSRC-1:0] status,
  output logic            irq
);
  logic            primed_q, primed_d;
  logic [NSRC-1:0] level, rise, clr;

  // Edge registers take one cycle after reset to load the live levels.
  always_comb primed_d = 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) primed_q <= 1'b0;
    else        primed_q <= primed_d;
  end

  sia_event_gate #(.CW(CW)) u_gate (
    .evt_wake(evt_wake), .fifo_ovf(fifo_ovf), .fifo_count(fifo_count),
    .fifo_wmark(fifo_wmark), .evt_trans(evt_trans), .evt_orient(evt_orient),
    .evt_pulse(evt_pulse), .evt_mot1(evt_mot1), .evt_mot2(evt_mot2),
    .drdy_new(drdy_new), .drdy_ovr(drdy_ovr), .irq_en(irq_en), .level(level)
  );

  sia_clear_decode #(.AW(AW)) u_clr (
    .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .rd_addr(rd_addr),
    .drdy_rise(rise[B_DRDY]), .drdy_bit(status[B_DRDY]), .clr(clr)
  );

  for (genvar g = 0; g < NSRC; g++) begin : g_bit
    sia_status_bit u_bit (
      .clk(clk), .rst_n(rst_n), .primed(primed_q), .level(level[g]),
      .clr(clr[g]), .rise(rise[g]), .bit_q(status[g])
    );
  end

  always_comb irq = |status;

  // R10: nothing can be latched before the edge registers hold real levels.
  assert_quiet_after_reset_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !primed_q |-> (status == '0));
  // R9: the request line follows the byte through every change.
  assert_irq_tracks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> (status == '0) && ($past(status) != '0));
endmodule

// File: tb/sns_irq_agg_bench.sv
module sns_irq_agg_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       evt_wake, fifo_ovf, evt_trans, evt_orient, evt_pulse;
  logic       evt_mot1, evt_mot2, drdy_new, drdy_ovr, rd_stb;
  logic [5:0] fifo_count, fifo_wmark;
  logic [7:0] irq_en, rd_addr, status;
  logic       irq;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  logic [7:0] q_exp[$];
  string      q_tag[$];

  // Reference model state, built from the requirements.
  logic [7:0] m_prev, m_stat;
  logic       m_primed, m_armed;

  always #5 clk = ~clk;

  sns_irq_agg u_sns_irq_agg (
    .clk(clk), .rst_n(rst_n), .evt_wake(evt_wake), .fifo_ovf(fifo_ovf),
    .fifo_count(fifo_count), .fifo_wmark(fifo_wmark), .evt_trans(evt_trans),
    .evt_orient(evt_orient), .evt_pulse(evt_pulse), .evt_mot1(evt_mot1),
    .evt_mot2(evt_mot2), .drdy_new(drdy_new), .drdy_ovr(drdy_ovr),
    .irq_en(irq_en), .rd_stb(rd_stb), .rd_addr(rd_addr), .status(status),
    .irq(irq)
  );

  task automatic check8(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  // Driver: models one clock edge and queues the expected byte.
  task automatic tick(input string tag);
    logic [7:0] lv, rs, cl;
    logic       drd;
    lv = {evt_wake, fifo_ovf | (fifo_count == fifo_wmark), evt_trans,
          evt_orient, evt_pulse, evt_mot1, evt_mot2, drdy_new | drdy_ovr} & irq_en;
    rs = m_primed ? (lv & ~m_prev) : 8'h00;
    drd = rd_stb && (rd_addr == 8'h28 || rd_addr == 8'h29 || rd_addr == 8'h2A);
    cl = 8'h00;
    if (rd_stb) begin
      for (int b = 1; b < 8; b++)
        if (rd_addr == 8'h20 + 8'(7 - b)) cl[b] = 1'b1;
    end
    cl[0] = m_armed && drd;
    if (rs[0])                                         m_armed = 1'b0;
    else if (cl[0])                                    m_armed = 1'b0;
    else if (rd_stb && rd_addr == 8'h27 && m_stat[0])  m_armed = 1'b1;
    m_stat   = rs | (m_stat & ~cl);
    m_prev   = lv;
    m_primed = 1'b1;
    q_exp.push_back(m_stat);
    q_tag.push_back(tag);
    @(negedge clk);
  endtask

  task automatic rd(input logic [7:0] a, input string tag);
    rd_stb = 1'b1; rd_addr = a;
    tick(tag);
    rd_stb = 1'b0; rd_addr = 8'h00;
  endtask

  // Monitor: compares after each rising edge.
  initial begin
    forever begin
      @(posedge clk); #2;
      if (q_exp.size() > 0) begin
        logic [7:0] e;
        string t;
        e = q_exp.pop_front();
        t = q_tag.pop_front();
        check8(status, e, t);
        checks++;
        if (irq !== (|e)) begin
          errors++;
          $display("FAIL R9 (%s): irq actual=%b expected=%b", t, irq, |e);
        end
      end
    end
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        errors++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
      end
    end
  end

  initial begin
    rst_n = 1'b0;
    evt_wake = 0; fifo_ovf = 0; evt_orient = 0; evt_pulse = 0;
    evt_mot1 = 0; evt_mot2 = 0; drdy_new = 0; drdy_ovr = 0;
    evt_trans = 1'b1;                 // high across reset: R10
    fifo_count = 6'd0; fifo_wmark = 6'd9;
    irq_en = 8'hFF; rd_stb = 0; rd_addr = 8'h00;
    m_prev = 8'h00; m_stat = 8'h00; m_primed = 1'b0; m_armed = 1'b0;
    repeat (3) @(negedge clk);
    check8(status, 8'h00, "R10 reset");
    rst_n = 1'b1;
    for (int i = 0; i < 3; i++) tick("R10 level high at reset");
    check8(status, 8'h00, "R10 no spurious set");

    // R2 / R1 transient at bit 5
    evt_trans = 0; tick("R2 low");
    evt_trans = 1; tick("R2 rise");
    check8(status, 8'h20, "R1 transient position");
    rd(8'h30, "R5 foreign read");
    rd(8'h23, "R5 other source read");
    rd(8'h22, "R5 transient clear");
    tick("R2 held level no reset");
    check8(status, 8'h00, "R2 no re-set on held level");
    evt_trans = 0;

    // Each plain source with its clear address
    evt_orient = 1; tick("R1 orient"); check8(status, 8'h10, "R1 orient bit4");
    rd(8'h23, "R5 orient clear"); evt_orient = 0;
    evt_pulse = 1; tick("R1 pulse"); check8(status, 8'h08, "R1 pulse bit3");
    rd(8'h24, "R5 pulse clear"); evt_pulse = 0;
    evt_mot1 = 1; tick("R1 mot1"); check8(status, 8'h04, "R1 mot1 bit2");
    rd(8'h25, "R5 mot1 clear"); evt_mot1 = 0;
    evt_mot2 = 1; tick("R1 mot2"); check8(status, 8'h02, "R1 mot2 bit1");
    rd(8'h26, "R5 mot2 clear"); evt_mot2 = 0;
    evt_wake = 1; tick("R6 wake"); check8(status, 8'h80, "R6 wake bit7");
    rd(8'h21, "R6 fifo read leaves wake");
    rd(8'h20, "R6 mode read clears"); evt_wake = 0;
    check8(status, 8'h00, "R6 cleared");

    // R3 enable masking
    irq_en = 8'hF7; evt_pulse = 1; tick("R3 masked"); tick("R3 masked");
    check8(status, 8'h00, "R3 masked pulse");
    irq_en = 8'hFF; tick("R3 enable while high");
    check8(status, 8'h08, "R3 enable sets");
    rd(8'h24, "R3 clear"); evt_pulse = 0;

    // R4 FIFO watermark and overflow
    fifo_count = 6'd8; tick("R4 below");
    fifo_count = 6'd9; tick("R4 watermark");
    check8(status, 8'h40, "R4 watermark");
    rd(8'h21, "R4 clear"); fifo_count = 6'd10; tick("R4 above");
    fifo_ovf = 1; tick("R4 overflow");
    check8(status, 8'h40, "R4 overflow");
    rd(8'h21, "R4 clear2"); fifo_ovf = 0; fifo_count = 6'd0;

    // R7 data ready two-step clear
    drdy_new = 1; tick("R7 new");
    rd(8'h28, "R7 axis only");
    check8(status, 8'h01, "R7 axis read alone");
    rd(8'h27, "R7 status read");
    drdy_new = 0; tick("R7 gap");
    drdy_ovr = 1; tick("R7 overrun edge cancels");
    rd(8'h29, "R7 axis after cancel");
    check8(status, 8'h01, "R7 cancelled arm");
    rd(8'h27, "R7 status read2");
    rd(8'h2A, "R7 axis clears");
    check8(status, 8'h00, "R7 cleared");
    drdy_ovr = 0;

    // R8 set beats clear
    evt_mot1 = 1; tick("R8 set"); evt_mot1 = 0; tick("R8 low");
    evt_mot1 = 1; rd(8'h25, "R8 set with clear");
    check8(status, 8'h04, "R8 set wins");
    rd(8'h25, "R8 clear"); evt_mot1 = 0;

    // R9 irq held until all cleared
    evt_orient = 1; evt_mot2 = 1; tick("R9 two bits");
    rd(8'h23, "R9 one cleared");
    checks++;
    if (irq !== 1'b1) begin errors++; $display("FAIL R9: irq actual=%b expected=1", irq); end
    rd(8'h26, "R9 all cleared");
    checks++;
    if (irq !== 1'b0) begin errors++; $display("FAIL R9: irq actual=%b expected=0", irq); end
    evt_orient = 0; evt_mot2 = 0;
    tick("idle"); tick("idle");
    @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule